// File: doc/BRIEF.md
# Synchronous Offset and FIFO Misuse Monitor

This block watches a SCSI synchronous data transfer and raises a gross-error flag when the transfer breaks its offset or FIFO rules. It counts the outstanding synchronous offset, which is the number of REQ pulses not yet answered by ACK pulses. It also watches the read, write and start strobes of the local data FIFO, using an occupancy count that the FIFO supplies. Six misuse conditions are numbered 1 to 6. When one of them fires, the block latches a flag and the number of that condition. Both outputs hold until software-side logic pulses a clear.

All inputs are plain single-cycle strobes or static levels. No data passes through the block, so it has no valid/ready interface and applies no back-pressure. The REQ and ACK strobes are one cycle wide per bus pulse and are counted the same way in either role. The role input selects which offset checks apply: initiator (low) or target (high). A programmed maximum offset of zero selects asynchronous transfer.

Top module: `scsi_offset_monitor`

## Requirements
- R1: A FIFO read strobe while `fifo_count` is 0 records cause code 1 (FIFO underflow).
- R2: A FIFO write strobe while `fifo_count` equals the FIFO depth, with no read strobe in the same cycle, records cause code 2 (FIFO overflow).
- R3: In target role with a nonzero maximum, an ACK strobe that arrives while the offset is 0 and no REQ strobe arrives in the same cycle records cause code 3 (offset underflow).
- R4: In initiator role with a nonzero maximum, a REQ strobe that would raise the offset above `max_offset` records cause code 4 (offset overflow). The count is then held at `max_offset`.
- R5: In initiator role, a `phase_chg` strobe while the offset is nonzero records cause code 5.
- R6: A `xfer_start` strobe with `xfer_sync_rx` low while `fifo_count` is nonzero records cause code 6 (residual data).
- R7: With a nonzero maximum, each REQ strobe adds one to the offset and each ACK strobe takes one away. A REQ and an ACK in the same cycle leave the offset unchanged.
- R8: With `max_offset` equal to 0, the offset stays at 0 and causes 3, 4 and 5 never fire.
- R9: A `xfer_start` strobe or an `err_clr` strobe sets the offset to 0.
- R10: `gross_err` and `err_cause` take their new values in the cycle after the error event. They then hold until `err_clr`, and later events do not change the recorded code.
- R11: When several causes fire in the same cycle, the lowest-numbered one is recorded.
- R12: After reset, `gross_err` is 0, `err_cause` is 0 and the offset is 0.
- R13: An `err_clr` strobe clears `gross_err` and `err_cause` to 0 in the next cycle. Any error events in the same cycle as the clear are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_tgt | input | 1 | 0 = initiator, 1 = target |
| max_offset | input | OFS_W | Programmed maximum offset; 0 = asynchronous |
| req_pulse | input | 1 | One strobe per REQ pulse on the bus |
| ack_pulse | input | 1 | One strobe per ACK pulse on the bus |
| phase_chg | input | 1 | Bus phase change strobe |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_sync_rx | input | 1 | Started transfer is a synchronous receive |
| fifo_rd | input | 1 | FIFO read strobe |
| fifo_wr | input | 1 | FIFO write strobe |
| fifo_count | input | CNT_W | FIFO occupancy, 0 to FIFO_DEPTH |
| err_clr | input | 1 | Clears the flag, the cause code and the offset |
| gross_err | output | 1 | Sticky gross-error flag |
| err_cause | output | 3 | Recorded cause, 1 to 6; 0 when no error is recorded |

## Verification
The bench sweeps each small maximum offset in both roles, stepping the pulse counts across the limit. A design with an off-by-one boundary would flag a legal transfer or miss the first illegal pulse. It also sweeps every FIFO occupancy for reads, writes and transfer starts, so a wrong empty or full compare shows up at exactly one count. Further cases cover simultaneous causes, events during a clear, and a second error after the first. A design with the wrong priority, a non-sticky code or a clear that loses to an event would record the wrong number or drop the flag.

// File: rtl/som_pkg.sv
package som_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_FIFO_UND = 3'd1,
    CAUSE_FIFO_OVF = 3'd2,
    CAUSE_OFS_UND  = 3'd3,
    CAUSE_OFS_OVF  = 3'd4,
    CAUSE_PHASE    = 3'd5,
    CAUSE_RESIDUAL = 3'd6
  } cause_e;

  localparam int unsigned NUM_CAUSES = 6;
endpackage

// File: rtl/som_offset_tracker.sv
module som_offset_tracker #(
  parameter int unsigned OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_tgt,
  input  logic [OFS_W-1:0] max_offset,
  input  logic             req_pulse,
  input  logic             ack_pulse,
  input  logic             phase_chg,
  input  logic             zero_req,
  output logic             ofs_under_evt,
  output logic             ofs_over_evt,
  output logic             phase_evt
);
  localparam int unsigned SUM_W = OFS_W + 1;

  logic [OFS_W-1:0] offset_q;
  logic [SUM_W-1:0] with_req;
  logic [SUM_W-1:0] next_ofs;
  logic             sync_mode;
  logic             would_under;
  logic             would_over;
  logic             take_ack;

  always_comb begin
    sync_mode   = (max_offset != '0);
    with_req    = {1'b0, offset_q} + SUM_W'(sync_mode && req_pulse);
    would_under = sync_mode && ack_pulse && (with_req == '0);
    take_ack    = sync_mode && ack_pulse && !would_under;
    next_ofs    = with_req - SUM_W'(take_ack);
    would_over  = sync_mode && (next_ofs > {1'b0, max_offset});
  end

  assign ofs_under_evt = would_under && role_tgt;
  assign ofs_over_evt  = would_over && !role_tgt;
  assign phase_evt     = phase_chg && !role_tgt && (offset_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
    end else if (zero_req) begin
      offset_q <= '0;
    end else if (would_over) begin
      offset_q <= max_offset;
    end else begin
      offset_q <= next_ofs[OFS_W-1:0];
    end
  end

  p_zero_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (offset_q == '0));

  p_async_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (max_offset == '0 && offset_q == '0) |=> (offset_q == '0));

  p_req_ack_balance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pulse && ack_pulse && !zero_req && max_offset != '0 && offset_q <= max_offset)
      |=> $stable(offset_q));
endmodule

// File: rtl/som_fifo_checker.sv
module som_fifo_checker #(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             fifo_rd,
  input  logic             fifo_wr,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             xfer_start,
  input  logic             xfer_sync_rx,
  output logic             fifo_under_evt,
  output logic             fifo_over_evt,
  output logic             residual_evt
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic is_empty;
  logic is_full;

  always_comb begin
    is_empty       = (fifo_count == '0);
    is_full        = (fifo_count >= FULL_CNT);
    fifo_under_evt = fifo_rd && is_empty;
    fifo_over_evt  = fifo_wr && !fifo_rd && is_full;
    residual_evt   = xfer_start && !xfer_sync_rx && !is_empty;
  end
endmodule

// File: rtl/som_err_latch.sv
module som_err_latch
  import som_pkg::*;
#(
  parameter int unsigned N = NUM_CAUSES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N:1]   events,
  input  logic         err_clr,
  output logic         gross_err,
  output logic [2:0]   err_cause
);
  cause_e pick;
  logic   flag_q;
  cause_e code_q;

  always_comb begin
    pick = CAUSE_NONE;
    for (int i = N; i >= 1; i--) begin
      if (events[i]) pick = cause_e'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      code_q <= CAUSE_NONE;
    end else if (err_clr) begin
      flag_q <= 1'b0;
      code_q <= CAUSE_NONE;
    end else if (!flag_q && pick != CAUSE_NONE) begin
      flag_q <= 1'b1;
      code_q <= pick;
    end
  end

  assign gross_err = flag_q;
  assign err_cause = code_q;

  p_clear_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (!gross_err && err_cause == 3'd0));

  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gross_err && !err_clr) |=> (gross_err && $stable(err_cause)));

  p_code_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gross_err |-> (err_cause != 3'd0 && err_cause <= 3'(N)));
endmodule

// File: rtl/scsi_offset_monitor.sv
module scsi_offset_monitor
  import som_pkg::*;
#(
  parameter int unsigned OFS_W      = 4,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_tgt,
  input  logic [OFS_W-1:0] max_offset,
  input  logic             req_pulse,
  input  logic             ack_pulse,
  input  logic             phase_chg,
  input  logic             xfer_start,
  input  logic             xfer_sync_rx,
  input  logic             fifo_rd,
  input  logic             fifo_wr,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             err_clr,
  output logic             gross_err,
  output logic [2:0]       err_cause
);
  logic [NUM_CAUSES:1] events;
  logic fifo_under_evt, fifo_over_evt, residual_evt;
  logic ofs_under_evt, ofs_over_evt, phase_evt;

  som_offset_tracker #(.OFS_W(OFS_W)) u_tracker (
    .clk           (clk),
    .rst_n         (rst_n),
    .role_tgt      (role_tgt),
    .max_offset    (max_offset),
    .req_pulse     (req_pulse),
    .ack_pulse     (ack_pulse),
    .phase_chg     (phase_chg),
    .zero_req      (xfer_start || err_clr),
    .ofs_under_evt (ofs_under_evt),
    .ofs_over_evt  (ofs_over_evt),
    .phase_evt     (phase_evt)
  );

  som_fifo_checker #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo_chk (
    .fifo_rd        (fifo_rd),
    .fifo_wr        (fifo_wr),
    .fifo_count     (fifo_count),
    .xfer_start     (xfer_start),
    .xfer_sync_rx   (xfer_sync_rx),
    .fifo_under_evt (fifo_under_evt),
    .fifo_over_evt  (fifo_over_evt),
    .residual_evt   (residual_evt)
  );

  always_comb begin
    events    = '0;
    events[1] = fifo_under_evt;
    events[2] = fifo_over_evt;
    events[3] = ofs_under_evt;
    events[4] = ofs_over_evt;
    events[5] = phase_evt;
    events[6] = residual_evt;
  end

  som_err_latch #(.N(NUM_CAUSES)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .events    (events),
    .err_clr   (err_clr),
    .gross_err (gross_err),
    .err_cause (err_cause)
  );

  p_empty_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && fifo_count == '0 && !err_clr && !gross_err) |=> (err_cause == 3'd1));

  p_residual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !xfer_sync_rx && fifo_count != '0 && !err_clr && !gross_err)
      |=> gross_err);
endmodule

// File: tb/scsi_offset_monitor_bench.sv
module scsi_offset_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 4;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic role_tgt = 1'b0;
  logic [OFS_W-1:0] max_offset = '0;
  logic req_pulse = 1'b0, ack_pulse = 1'b0, phase_chg = 1'b0;
  logic xfer_start = 1'b0, xfer_sync_rx = 1'b0;
  logic fifo_rd = 1'b0, fifo_wr = 1'b0;
  logic [CNT_W-1:0] fifo_count = '0;
  logic err_clr = 1'b0;
  logic gross_err;
  logic [2:0] err_cause;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_offset_monitor #(.OFS_W(OFS_W), .FIFO_DEPTH(DEPTH)) u_scsi_offset_monitor (
    .clk(clk), .rst_n(rst_n), .role_tgt(role_tgt), .max_offset(max_offset),
    .req_pulse(req_pulse), .ack_pulse(ack_pulse), .phase_chg(phase_chg),
    .xfer_start(xfer_start), .xfer_sync_rx(xfer_sync_rx),
    .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .fifo_count(fifo_count),
    .err_clr(err_clr), .gross_err(gross_err), .err_cause(err_cause)
  );

  task automatic chk(input int exp_code, input string tag);
    logic exp_flag;
    exp_flag = (exp_code != 0);
    checks++;
    if (err_cause != 3'(exp_code) || gross_err != exp_flag) begin
      errors++;
      $display("FAIL %s: flag=%0b cause=%0d expected flag=%0b cause=%0d",
               tag, gross_err, err_cause, exp_flag, exp_code);
    end
  endtask

  // one-cycle strobe: bits {clr, req, ack, phase, start, srx, rd, wr}
  task automatic pulse(input logic [7:0] s);
    @(negedge clk);
    {err_clr, req_pulse, ack_pulse, phase_chg, xfer_start, xfer_sync_rx, fifo_rd, fifo_wr} = s;
    @(negedge clk);
    {err_clr, req_pulse, ack_pulse, phase_chg, xfer_start, xfer_sync_rx, fifo_rd, fifo_wr} = '0;
  endtask

  localparam logic [7:0] S_CLR = 8'h80, S_REQ = 8'h40, S_ACK = 8'h20, S_PH = 8'h10;
  localparam logic [7:0] S_ST = 8'h08, S_SRX = 8'h04, S_RD = 8'h02, S_WR = 8'h01;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(0, "R12 reset state");

    // R4 / R7: initiator, k REQs against each maximum
    role_tgt = 1'b0;
    for (int m = 1; m <= 5; m++) begin
      for (int k = 1; k <= m + 1; k++) begin
        max_offset = OFS_W'(m);
        pulse(S_CLR);
        for (int i = 0; i < k; i++) pulse(S_REQ);
        chk((k > m) ? 4 : 0, "R4 REQ count vs maximum");
      end
    end
    // REQ and ACK together at the limit: no overflow (R7)
    max_offset = 4'd2;
    pulse(S_CLR); pulse(S_REQ); pulse(S_REQ); pulse(S_REQ | S_ACK);
    chk(0, "R7 simultaneous REQ and ACK at maximum");

    // R3: target, balanced then one extra ACK
    role_tgt = 1'b1;
    for (int m = 1; m <= 4; m++) begin
      for (int k = 0; k <= m; k++) begin
        max_offset = OFS_W'(m);
        pulse(S_CLR);
        for (int i = 0; i < k; i++) pulse(S_REQ);
        for (int i = 0; i < k; i++) pulse(S_ACK);
        chk(0, "R7 balanced ACKs in target role");
        pulse(S_ACK);
        chk(3, "R3 ACK at zero offset in target role");
      end
    end
    // REQ and ACK together at zero: no underflow
    max_offset = 4'd3;
    pulse(S_CLR); pulse(S_REQ | S_ACK);
    chk(0, "R3 REQ with ACK at zero offset");

    // R5 / R7: initiator phase change after k REQs, j ACKs
    role_tgt = 1'b0;
    max_offset = 4'd4;
    for (int k = 0; k <= 4; k++) begin
      for (int j = 0; j <= k; j++) begin
        pulse(S_CLR);
        for (int i = 0; i < k; i++) pulse(S_REQ);
        for (int i = 0; i < j; i++) pulse(S_ACK);
        pulse(S_PH);
        chk((k != j) ? 5 : 0, "R5 phase change with outstanding offset");
      end
    end
    // target role: phase change with offset is not an error
    role_tgt = 1'b1;
    pulse(S_CLR); pulse(S_REQ); pulse(S_PH);
    chk(0, "R5 phase change ignored in target role");

    // R1 / R2 / R6: sweep every FIFO occupancy
    role_tgt = 1'b0;
    max_offset = 4'd3;
    for (int c = 0; c <= DEPTH; c++) begin
      fifo_count = CNT_W'(c);
      pulse(S_CLR); pulse(S_RD);
      chk((c == 0) ? 1 : 0, "R1 read vs occupancy");
      pulse(S_CLR); pulse(S_WR);
      chk((c == DEPTH) ? 2 : 0, "R2 write vs occupancy");
      if (c != 0) begin
        pulse(S_CLR); pulse(S_WR | S_RD);
        chk(0, "R2 write with read in same cycle");
      end
      pulse(S_CLR); pulse(S_ST);
      chk((c != 0) ? 6 : 0, "R6 non-sync start vs occupancy");
      pulse(S_CLR); pulse(S_ST | S_SRX);
      chk(0, "R6 sync receive start with data");
    end
    fifo_count = '0;

    // R8: asynchronous mode
    max_offset = '0;
    role_tgt = 1'b0;
    pulse(S_CLR);
    for (int i = 0; i < 20; i++) pulse(S_REQ);
    chk(0, "R8 async REQs never overflow");
    pulse(S_PH);
    chk(0, "R8 async phase change");
    role_tgt = 1'b1;
    pulse(S_ACK);
    chk(0, "R8 async ACK never underflows");

    // R9: start and clear zero the offset
    role_tgt = 1'b0;
    max_offset = 4'd3;
    pulse(S_CLR); pulse(S_REQ); pulse(S_REQ); pulse(S_ST | S_SRX); pulse(S_PH);
    chk(0, "R9 start zeroes offset");
    pulse(S_REQ); pulse(S_REQ); pulse(S_CLR); pulse(S_PH);
    chk(0, "R9 clear zeroes offset");
    pulse(S_REQ); pulse(S_REQ); pulse(S_REQ); pulse(S_ST | S_SRX); pulse(S_REQ);
    pulse(S_REQ); pulse(S_REQ);
    chk(0, "R9 full window again after start");

    // R11: priority
    role_tgt = 1'b1;
    pulse(S_CLR); pulse(S_RD | S_ACK);
    chk(1, "R11 underflow beats offset underflow");
    role_tgt = 1'b0;
    fifo_count = CNT_W'(DEPTH);
    pulse(S_CLR); pulse(S_WR | S_ST);
    chk(2, "R11 overflow beats residual");
    fifo_count = '0;
    pulse(S_CLR); pulse(S_REQ); pulse(S_PH | S_RD);
    chk(1, "R11 underflow beats phase error");

    // R10: sticky code, timing
    pulse(S_CLR);
    @(negedge clk);
    fifo_rd = 1'b1;
    @(posedge clk); #1;
    fifo_rd = 1'b0;
    chk(1, "R10 flag set one cycle after event");
    fifo_count = CNT_W'(DEPTH);
    pulse(S_WR);
    fifo_count = '0;
    repeat (3) @(negedge clk);
    chk(1, "R10 later event keeps first code");

    // R13: clear beats same-cycle event
    pulse(S_CLR | S_RD);
    chk(0, "R13 event dropped during clear");
    pulse(S_RD);
    chk(1, "R13 detection resumes after clear");
    pulse(S_CLR);
    chk(0, "R13 clear empties flag and code");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule